// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block moves the system clock from a slow secondary oscillator back to a primary oscillator. The primary path can run either straight from the primary input or through a PLL. Software sets a select request to start the move. The sequencer then holds the system on the secondary clock while the primary settles. The length of that settle depends on the configured primary mode. A crystal primary needs a start-up count, and any PLL mode needs a lock time-out on top of that.

Once the settle is finished, the sequencer waits for the end of a four-phase instruction cycle. At that point it commits the handover. A break-before-make gate then moves the output clock from the old source to the new one without producing a runt pulse. A status flag reports which source drives the system clock. If the request is withdrawn before the handover, the sequencer abandons the attempt. If the request is withdrawn after the handover, the sequencer switches back to the secondary clock.

Top module: `clksw_seq`

## Requirements
- R1: After reset, `sel_pri` and `on_pri` are 0 and `sys_clk` runs at the secondary clock rate.
- R2: With `pri_mode` = 2'b00 (crystal with PLL), the handover does not happen before OST_CYC plus PLL_CYC primary cycles have passed since the request. It does happen within a small fixed number of further primary cycles.
- R3: With `pri_mode` = 2'b10 (crystal, no PLL), only the start-up count of OST_CYC primary cycles is applied before the handover. OST_CYC defaults to 1024.
- R4: With `pri_mode` = 2'b01 (external clock with PLL), the start-up count is skipped and only the PLL_CYC lock time-out is applied.
- R5: With `pri_mode` = 2'b11 (external clock, no PLL), no settle wait is applied; only the synchroniser latency separates the request from the handover.
- R6: `sel_pri` rises only on a secondary clock edge that ends a group of four phases. The phases are counted from the first edge after reset is released, so the rising edge is always edge number 4k.
- R7: Clearing `sel_req` before the handover cancels the switch: `sel_pri` stays 0. A later request starts the complete settle wait again from zero.
- R8: `on_pri` becomes 1 only after the handover completes, and only while `sel_pri` is 1.
- R9: The output clock never carries a pulse shorter than the narrower half-period of the two sources. The two gate enables are never both active.
- R10: Clearing `sel_req` while on the primary drops `sel_pri` at once. `on_pri` then clears, and `sys_clk` returns to the secondary rate.
- R11: After the handover, `sys_clk` runs at the PLL rate in PLL modes (`pri_mode[1]` = 0) and at the raw primary rate otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sec | input | 1 | Secondary (slow) oscillator clock; the sequencer's own clock |
| clk_pri | input | 1 | Primary oscillator input clock; the settle counts run on it |
| clk_pll | input | 1 | PLL output clock |
| rst | input | 1 | Synchronous active-high reset, held across several cycles of every clock |
| pri_mode | input | 2 | Primary mode: bit 0 = 0 applies the start-up count, bit 1 = 0 routes through the PLL |
| sel_req | input | 1 | Select request; 1 asks for the primary, 0 asks for the secondary |
| sys_clk | output | 1 | Glitch-free system clock |
| sel_pri | output | 1 | Registered clock-select control, committed at a phase boundary |
| on_pri | output | 1 | Status: the primary path is driving `sys_clk` |

## Verification
The assertions check the following on every secondary clock cycle:
- the select rises only at the last instruction phase;
- the select rises only after the synchronised settle-done flag;
- the select rises only while the request is held;
- the status never leads the select;
- the two gate enables are never both open;
- clearing the request while on the primary drops the select on the next cycle.

Only the bench scenarios can show the settle lengths, measured in primary cycles for each of the four modes. The same holds for the restart from zero after an aborted request, the output frequency before and after each switch, and the absence of narrow pulses across every transition.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

  typedef enum logic [1:0] {
    PM_XTAL_PLL = 2'b00,
    PM_EXT_PLL  = 2'b01,
    PM_XTAL     = 2'b10,
    PM_EXT      = 2'b11
  } pri_mode_e;

  typedef enum logic [2:0] {
    SQ_SEC,
    SQ_WAIT,
    SQ_ALIGN,
    SQ_HAND,
    SQ_PRI,
    SQ_BACK
  } seq_state_e;

  typedef enum logic [1:0] {
    TS_IDLE,
    TS_OST,
    TS_PLL,
    TS_DONE
  } tmr_stage_e;

  // bit 1 low selects the PLL path
  function automatic logic mode_uses_pll(input logic [1:0] m);
    return ~m[1];
  endfunction

  // bit 0 low selects a crystal, which needs the start-up count
  function automatic logic mode_uses_ost(input logic [1:0] m);
    return ~m[0];
  endfunction

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= '0;
        else     pipe[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= '0;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/clksw_settle_tmr.sv
`timescale 1ns/1ps
module clksw_settle_tmr
  import clksw_pkg::*;
#(
  parameter int OST_CYC = 1024,
  parameter int PLL_CYC = 20000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] mode,
  output logic       done
);

  localparam int MAXC = (OST_CYC > PLL_CYC) ? OST_CYC : PLL_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  tmr_stage_e    stg;
  logic [CW-1:0] cnt;

  // dropping run clears everything, so a new request always starts from zero
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      stg  <= TS_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= (stg == TS_DONE);
      case (stg)
        TS_IDLE: begin
          cnt <= '0;
          if (mode_uses_ost(mode))      stg <= TS_OST;
          else if (mode_uses_pll(mode)) stg <= TS_PLL;
          else                          stg <= TS_DONE;
        end
        TS_OST: begin
          if (cnt == CW'(OST_CYC - 1)) begin
            cnt <= '0;
            stg <= mode_uses_pll(mode) ? TS_PLL : TS_DONE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        TS_PLL: begin
          if (cnt == CW'(PLL_CYC - 1)) begin
            cnt <= '0;
            stg <= TS_DONE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        TS_DONE: stg <= TS_DONE;
      endcase
    end
  end

endmodule

// File: rtl/clksw_gmux.sv
`timescale 1ns/1ps
module clksw_gmux (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst,
  input  logic sel_b,
  output logic clk_o,
  output logic en_a,
  output logic en_b
);

  logic a_m, b_m;

  // side A: open only when B is shut, enable changes while clk_a is low
  always_ff @(posedge clk_a) begin
    if (rst) a_m <= 1'b1;
    else     a_m <= ~sel_b & ~en_b;
  end

  always_ff @(negedge clk_a) begin
    if (rst) en_a <= 1'b1;
    else     en_a <= a_m;
  end

  // side B: open only when A is shut, enable changes while clk_b is low
  always_ff @(posedge clk_b) begin
    if (rst) b_m <= 1'b0;
    else     b_m <= sel_b & ~en_a;
  end

  always_ff @(negedge clk_b) begin
    if (rst) en_b <= 1'b0;
    else     en_b <= b_m;
  end

  assign clk_o = (clk_a & en_a) | (clk_b & en_b);

endmodule

// File: rtl/clksw_seq.sv
`timescale 1ns/1ps
module clksw_seq
  import clksw_pkg::*;
#(
  parameter int OST_CYC  = 1024,
  parameter int PRI_KHZ  = 10000,
  parameter int PLL_US   = 2000,
  parameter int PLL_CYC  = PRI_KHZ * PLL_US / 1000,
  parameter int QPH      = 4,
  parameter int SYNC_STG = 2
) (
  input  logic       clk_sec,
  input  logic       clk_pri,
  input  logic       clk_pll,
  input  logic       rst,
  input  logic [1:0] pri_mode,
  input  logic       sel_req,
  output logic       sys_clk,
  output logic       sel_pri,
  output logic       on_pri
);

  localparam int QW = (QPH > 1) ? $clog2(QPH) : 1;
  localparam logic [QW-1:0] Q_LAST = QW'(QPH - 1);

  seq_state_e    st;
  logic [QW-1:0] q_ph;
  logic          run_q, run_s;
  logic          done_p, done_s;
  logic          en_a, en_b, en_b_s;
  logic          clk_new;

  // selected destination clock; mode is held steady while a switch is active
  assign clk_new = mode_uses_pll(pri_mode) ? clk_pll : clk_pri;

  clksw_sync #(.STAGES(SYNC_STG), .W(1)) u_run_sync (
    .clk(clk_pri), .rst(rst), .d(run_q), .q(run_s)
  );

  clksw_settle_tmr #(.OST_CYC(OST_CYC), .PLL_CYC(PLL_CYC)) u_tmr (
    .clk(clk_pri), .rst(rst), .run(run_s), .mode(pri_mode), .done(done_p)
  );

  clksw_sync #(.STAGES(SYNC_STG), .W(1)) u_done_sync (
    .clk(clk_sec), .rst(rst), .d(done_p), .q(done_s)
  );

  clksw_gmux u_mux (
    .clk_a(clk_sec), .clk_b(clk_new), .rst(rst), .sel_b(sel_pri),
    .clk_o(sys_clk), .en_a(en_a), .en_b(en_b)
  );

  clksw_sync #(.STAGES(SYNC_STG), .W(1)) u_enb_sync (
    .clk(clk_sec), .rst(rst), .d(en_b), .q(en_b_s)
  );

  always_ff @(posedge clk_sec) begin
    if (rst) begin
      st      <= SQ_SEC;
      q_ph    <= '0;
      run_q   <= 1'b0;
      sel_pri <= 1'b0;
      on_pri  <= 1'b0;
    end else begin
      q_ph <= (q_ph == Q_LAST) ? '0 : q_ph + QW'(1);
      case (st)
        // wait for stale done/enable of an earlier attempt to drain first
        SQ_SEC: if (sel_req && !done_s && !en_b_s) begin
          st    <= SQ_WAIT;
          run_q <= 1'b1;
        end
        SQ_WAIT: begin
          if (!sel_req) begin
            st    <= SQ_SEC;
            run_q <= 1'b0;
          end else if (done_s) begin
            st <= SQ_ALIGN;
          end
        end
        SQ_ALIGN: begin
          if (!sel_req) begin
            st    <= SQ_SEC;
            run_q <= 1'b0;
          end else if (q_ph == Q_LAST) begin
            st      <= SQ_HAND;
            sel_pri <= 1'b1;
          end
        end
        SQ_HAND: if (en_b_s) begin
          st     <= SQ_PRI;
          on_pri <= 1'b1;
        end
        SQ_PRI: if (!sel_req) begin
          st      <= SQ_BACK;
          sel_pri <= 1'b0;
          run_q   <= 1'b0;
        end
        SQ_BACK: if (!en_b_s) begin
          st     <= SQ_SEC;
          on_pri <= 1'b0;
        end
        default: st <= SQ_SEC;
      endcase
    end
  end

endmodule

// File: rtl/clksw_seq_chk.sv
`timescale 1ns/1ps
module clksw_seq_chk #(
  parameter int QPH = 4,
  parameter int QW  = 2
) (
  input logic          clk_sec,
  input logic          rst,
  input logic          sel_req,
  input logic          sel_pri,
  input logic          on_pri,
  input logic [QW-1:0] q_ph,
  input logic          done_s,
  input logic          en_a,
  input logic          en_b
);

  a_r6_phase_edge: assert property (@(posedge clk_sec) disable iff (rst)
    $rose(sel_pri) |-> ($past(q_ph) == QW'(QPH - 1)));

  a_r2_settled_first: assert property (@(posedge clk_sec) disable iff (rst)
    $rose(sel_pri) |-> $past(done_s));

  a_r7_needs_request: assert property (@(posedge clk_sec) disable iff (rst)
    $rose(sel_pri) |-> $past(sel_req));

  a_r8_status_after_select: assert property (@(posedge clk_sec) disable iff (rst)
    on_pri |-> sel_pri || $past(!sel_req));

  a_r9_break_before_make: assert property (@(posedge clk_sec) disable iff (rst)
    !(en_a && en_b));

  a_r10_return_drops: assert property (@(posedge clk_sec) disable iff (rst)
    (on_pri && !sel_req) |=> !sel_pri);

endmodule

bind clksw_seq clksw_seq_chk #(.QPH(QPH), .QW(QW)) u_chk (
  .clk_sec(clk_sec),
  .rst(rst),
  .sel_req(sel_req),
  .sel_pri(sel_pri),
  .on_pri(on_pri),
  .q_ph(q_ph),
  .done_s(done_s),
  .en_a(en_a),
  .en_b(en_b)
);

// File: tb/clksw_seq_tb.sv
`timescale 1ns/1ps
module clksw_seq_tb;

  localparam int OST   = 1024;
  localparam int PLLC  = 64;
  localparam int SLACK = 120;

  logic       clk_sec = 1'b0;
  logic       clk_pri = 1'b0;
  logic       clk_pll = 1'b0;
  logic       rst     = 1'b1;
  logic       sel_req = 1'b0;
  logic [1:0] pri_mode = 2'b00;
  logic       sys_clk, sel_pri, on_pri;

  always #8 clk_sec = ~clk_sec;
  always #2 clk_pri = ~clk_pri;   // 250 MHz primary
  always #1 clk_pll = ~clk_pll;

  clksw_seq #(.OST_CYC(OST), .PLL_CYC(PLLC)) u_dut (
    .clk_sec(clk_sec), .clk_pri(clk_pri), .clk_pll(clk_pll), .rst(rst),
    .pri_mode(pri_mode), .sel_req(sel_req),
    .sys_clk(sys_clk), .sel_pri(sel_pri), .on_pri(on_pri)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  int pcnt = 0;
  always @(posedge clk_pri) pcnt <= pcnt + 1;

  int ecnt = 0;
  always @(posedge clk_sec) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  int sc = 0;
  always @(posedge sys_clk) sc <= sc + 1;

  // R6: select rises only on edge number 4k; R8: status never ahead of select
  logic sel_d = 1'b0;
  int   r8_bad = 0;
  always @(negedge clk_sec) begin
    if (sel_pri && !sel_d) chk((ecnt % 4) == 0, "R6", ecnt % 4, 0);
    if (on_pri && !sel_pri && sel_req) r8_bad++;
    sel_d <= sel_pri;
  end

  bit guard = 1'b0;
  int abort_hits = 0;
  always @(negedge clk_sec) if (guard && sel_pri) abort_hits++;

  // R9: narrow-pulse monitor
  realtime last_t = 0.0;
  bit      runt_on = 1'b0;
  int      runts = 0;
  always @(sys_clk) begin
    if (runt_on && ($realtime - last_t) < 0.5) runts++;
    last_t = $realtime;
  end

  task automatic do_reset();
    @(negedge clk_sec);
    rst     = 1'b1;
    sel_req = 1'b0;
    repeat (6) @(negedge clk_sec);
    rst = 1'b0;
    @(negedge clk_sec);
  endtask

  task automatic rate(output int n);
    int a;
    a = sc;
    #160;
    n = sc - a;
  endtask

  task automatic switch_on(output int dur);
    int t0;
    int n;
    @(negedge clk_sec);
    sel_req = 1'b1;
    t0 = pcnt;
    n = 0;
    while (!on_pri && n < 3000) begin
      @(negedge clk_sec);
      n++;
    end
    dur = pcnt - t0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int dur;
    int base;
    int n_back;
    string tag;
    do_reset();
    runt_on = 1'b1;

    for (int m = 0; m < 4; m++) begin
      logic [1:0] mm;
      mm = 2'(m);
      pri_mode = mm;
      do_reset();
      chk(sel_pri == 1'b0, "R1", int'(sel_pri), 0);
      chk(on_pri == 1'b0, "R1", int'(on_pri), 0);
      rate(n);
      chk(n == 10, "R1", n, 10);

      base = (mm[0] ? 0 : OST) + (mm[1] ? 0 : PLLC);
      case (mm)
        2'b00:   tag = "R2";
        2'b01:   tag = "R4";
        2'b10:   tag = "R3";
        default: tag = "R5";
      endcase
      switch_on(dur);
      chk(on_pri == 1'b1, tag, int'(on_pri), 1);
      chk(dur >= base && dur <= base + SLACK, tag, dur, base);
      chk(sel_pri == 1'b1, "R8", int'(sel_pri), 1);

      rate(n);
      chk(n == (mm[1] ? 40 : 80), "R11", n, mm[1] ? 40 : 80);

      @(negedge clk_sec);
      sel_req = 1'b0;
      @(negedge clk_sec);
      chk(sel_pri == 1'b0, "R10", int'(sel_pri), 0);
      n_back = 0;
      while (on_pri && n_back < 100) begin
        @(negedge clk_sec);
        n_back++;
      end
      chk(on_pri == 1'b0, "R10", int'(on_pri), 0);
      @(negedge clk_sec);
      rate(n);
      chk(n == 10, "R10", n, 10);
    end

    // R7: withdraw mid-settle, then request again from zero
    pri_mode = 2'b00;
    do_reset();
    @(negedge clk_sec);
    sel_req = 1'b1;
    repeat (75) @(negedge clk_sec);
    guard   = 1'b1;
    sel_req = 1'b0;
    repeat (400) @(negedge clk_sec);
    chk(abort_hits == 0, "R7", abort_hits, 0);
    chk(on_pri == 1'b0, "R7", int'(on_pri), 0);
    guard = 1'b0;
    switch_on(dur);
    chk(dur >= OST + PLLC && dur <= OST + PLLC + SLACK, "R7", dur, OST + PLLC);
    @(negedge clk_sec);
    sel_req = 1'b0;
    repeat (20) @(negedge clk_sec);

    chk(runts == 0, "R9", runts, 0);
    chk(r8_bad == 0, "R8", r8_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule